// File: doc/BRIEF.md
# External Area Chip-Select Decoder

This block sits between the core's address bus and the external memory pins. The top three bits of a 24-bit access address pick one of eight 2 MB areas. Accesses that fall in on-chip ROM, on-chip RAM or the internal register window are kept on chip and flagged. Every other access either goes off chip, in expanded mode, or is flagged invalid, in single-chip mode. An off-chip access pulls the active-low select of its area low for one registered cycle. The select is only pulsed on a cycle where the access strobe is high, so the pins never glitch while the address settles.

Software can give each area an interface kind: plain bus, burst ROM or DRAM. Each area accepts only some kinds. A write asking for a kind the area does not support is dropped. An area among 2 to 5 that is set to DRAM does not drive its chip select. It drives a row-strobe output of its own instead. A merge setting joins areas 2 to 5 into one large DRAM range behind the first row strobe. The interface kind of each external access is also output, so that the bus-cycle engine can pick its timing.

Top module: `area_cs_decoder`

## Requirements
- R1: While reset is active and after it is released, all of `cs_n` and `ras_n` are high, every hit flag is 0, `acc_iface` is 00, every area's interface kind is plain bus (00), and merge is off.
- R2: The area index is `acc_addr[23:21]`. An external access to area k (0 to 6) that does not use a row strobe drives only `cs_n[k]` low, with `hit_ext` high, in the cycle after the strobe edge. No other select or strobe goes low.
- R3: In area 0, addresses below 0x040000 are on-chip ROM while `rom_enable` is 1. They set `hit_rom` and drive no select. With ROM disabled, or at 0x040000 and above, area 0 is external.
- R4: In area 7, 0xFFF000 to 0xFFFFFF always sets `hit_reg`. 0xFFB000 to 0xFFEFFF sets `hit_ram` only while `ram_enable` is 1, and is external otherwise. The rest of area 7 is external and drives no select, because area 7 has none.
- R5: Interface kinds are encoded 00 plain bus, 01 burst ROM, 10 DRAM and 11 reserved. Areas 0 and 1 accept 00 or 01. Areas 2 to 5 accept 00 or 10. Areas 6 and 7 accept only 00. A write with a kind the area does not accept is ignored, and the area keeps its kind.
- R6: An external access to an area among 2 to 5 whose kind is DRAM drives `ras_n[k-2]` low instead of `cs_n[k]`.
- R7: While merge is on, every external access to areas 2 to 5 is treated as DRAM and drives only `ras_n[0]`, whatever kind each area holds.
- R8: With `mode_expanded` at 0, no select or row strobe is ever driven. Accesses that are not on chip set `hit_bad` instead of `hit_ext`.
- R9: A clock edge without `acc_strobe` returns all selects and strobes high, all flags to 0 and `acc_iface` to 00.
- R10: A configuration write and an access in the same cycle: the access is decoded with the kinds held before that write. The new kind applies from the next access on.
- R11: `acc_iface` reports the effective interface kind of an external access: 10 for an access that uses a row strobe, the area's kind otherwise. It reports 00 for accesses that stay on chip or are invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_expanded | input | 1 | 1 = external bus enabled, 0 = single-chip |
| rom_enable | input | 1 | On-chip ROM enabled |
| ram_enable | input | 1 | On-chip RAM enabled |
| cfg_wr | input | 1 | Write an area's interface kind |
| cfg_area | input | 3 | Area addressed by the write |
| cfg_iface | input | 2 | Requested interface kind |
| cfg_merge_wr | input | 1 | Write the merge setting |
| cfg_merge | input | 1 | New merge setting |
| acc_strobe | input | 1 | Access valid this cycle |
| acc_addr | input | 24 | Access address |
| cs_n | output | 7 | Active-low area selects, areas 0 to 6 |
| ras_n | output | 4 | Active-low row strobes, areas 2 to 5 |
| acc_iface | output | 2 | Effective interface kind of the access |
| hit_rom | output | 1 | Access went to on-chip ROM |
| hit_ram | output | 1 | Access went to on-chip RAM |
| hit_reg | output | 1 | Access went to internal registers |
| hit_ext | output | 1 | Access went off chip |
| hit_bad | output | 1 | Off-chip access in single-chip mode |

## Verification
A configuration write and a decoded access can happen in the same clock cycle. Which kind the access then sees is a question of ordering. The bench raises `cfg_wr` together with `acc_strobe` for the same area, turning area 4 into DRAM. It expects the old plain-bus select on that access and the row strobe only on the following access. The merge register raises the same question. A checker property ties the row-strobe pins to the merge value held one cycle earlier, not the current one.

// File: rtl/acd_pkg.sv
package acd_pkg;

  localparam int AREA_W     = 3;
  localparam int NUM_AREAS  = 1 << AREA_W;
  localparam int NUM_CS     = NUM_AREAS - 1;
  localparam int DRAM_FIRST = 2;
  localparam int DRAM_LAST  = 5;
  localparam int NUM_RAS    = DRAM_LAST - DRAM_FIRST + 1;

  typedef enum logic [1:0] {
    IF_BASIC = 2'b00,
    IF_BURST = 2'b01,
    IF_DRAM  = 2'b10,
    IF_RSVD  = 2'b11
  } iface_e;

  typedef enum logic [2:0] {
    SP_ROM = 3'd0,
    SP_RAM = 3'd1,
    SP_REG = 3'd2,
    SP_EXT = 3'd3,
    SP_BAD = 3'd4
  } space_e;

  // true when the area sits in the row-strobe capable group
  function automatic logic is_dram_area(input logic [AREA_W-1:0] area);
    return (area >= AREA_W'(DRAM_FIRST)) && (area <= AREA_W'(DRAM_LAST));
  endfunction

  // legality of an interface kind for a given area
  function automatic logic iface_allowed(input logic [AREA_W-1:0] area,
                                         input logic [1:0] kind);
    logic ok;
    case (kind)
      IF_BASIC: ok = 1'b1;
      IF_BURST: ok = (area <= AREA_W'(1));
      IF_DRAM:  ok = is_dram_area(area);
      default:  ok = 1'b0;
    endcase
    return ok;
  endfunction

  // which row strobe an area uses; merged space always uses the first
  function automatic logic [1:0] ras_slot(input logic [AREA_W-1:0] area,
                                          input logic merged);
    logic [AREA_W-1:0] diff;
    diff = area - AREA_W'(DRAM_FIRST);
    return merged ? 2'd0 : diff[1:0];
  endfunction

  // half-open window test on a 32-bit widened address
  function automatic logic in_window(input logic [31:0] addr,
                                     input logic [31:0] base,
                                     input logic [31:0] size);
    return (addr >= base) && ((addr - base) < size);
  endfunction

endpackage

// File: rtl/acd_cfg_regs.sv
module acd_cfg_regs
  import acd_pkg::*;
#(
  parameter int AREAS = NUM_AREAS
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [AREA_W-1:0]           wr_area,
  input  logic [1:0]                  wr_kind,
  input  logic                        merge_wr,
  input  logic                        merge_in,
  output logic [AREAS-1:0][1:0]       kinds_q,
  output logic                        merge_q
);

  for (genvar g = 0; g < AREAS; g++) begin : g_area
    logic [1:0] kind_r;
    logic       addressed;
    logic       accept;

    assign addressed = wr_en && (wr_area == AREA_W'(g));
    assign accept    = addressed && iface_allowed(AREA_W'(g), wr_kind);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        kind_r <= IF_BASIC;
      end else if (accept) begin
        kind_r <= wr_kind;
      end
    end

    assign kinds_q[g] = kind_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      merge_q <= 1'b0;
    end else if (merge_wr) begin
      merge_q <= merge_in;
    end
  end

endmodule

// File: rtl/acd_region_decode.sv
module acd_region_decode
  import acd_pkg::*;
#(
  parameter int          ADDR_W   = 24,
  parameter logic [31:0] ROM_SIZE = 32'h0004_0000,
  parameter logic [31:0] RAM_BASE = 32'h00FF_B000,
  parameter logic [31:0] RAM_SIZE = 32'h0000_4000,
  parameter logic [31:0] REG_BASE = 32'h00FF_F000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              mode_expanded,
  input  logic              rom_enable,
  input  logic              ram_enable,
  output logic [AREA_W-1:0] area,
  output space_e            space
);

  localparam logic [AREA_W-1:0] TOP_AREA = AREA_W'(NUM_AREAS - 1);

  logic [31:0] addr_w;
  logic        rom_hit;
  logic        ram_hit;
  logic        reg_hit;

  assign addr_w  = 32'(addr);
  assign area    = addr[ADDR_W-1 -: AREA_W];

  assign rom_hit = (area == '0) && rom_enable && (addr_w < ROM_SIZE);
  assign reg_hit = (area == TOP_AREA) && (addr_w >= REG_BASE);
  assign ram_hit = (area == TOP_AREA) && ram_enable &&
                   in_window(addr_w, RAM_BASE, RAM_SIZE);

  always_comb begin
    if (rom_hit)            space = SP_ROM;
    else if (reg_hit)       space = SP_REG;
    else if (ram_hit)       space = SP_RAM;
    else if (mode_expanded) space = SP_EXT;
    else                    space = SP_BAD;
  end

endmodule

// File: rtl/acd_select_drive.sv
module acd_select_drive
  import acd_pkg::*;
#(
  parameter int AREAS      = NUM_AREAS,
  parameter int NUM_SEL    = NUM_CS,
  parameter int NUM_STROBE = NUM_RAS
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    strobe,
  input  logic [AREA_W-1:0]       area,
  input  space_e                  space,
  input  logic [AREAS-1:0][1:0]   kinds,
  input  logic                    merged,
  output logic [NUM_SEL-1:0]      cs_n,
  output logic [NUM_STROBE-1:0]   ras_n,
  output logic [1:0]              acc_iface,
  output logic                    hit_rom,
  output logic                    hit_ram,
  output logic                    hit_reg,
  output logic                    hit_ext,
  output logic                    hit_bad
);

  logic                  go_ext;
  logic                  in_dram_grp;
  logic [1:0]            eff_kind;
  logic                  use_ras;
  logic [1:0]            slot;
  logic [NUM_SEL-1:0]    cs_hit;
  logic [NUM_STROBE-1:0] ras_hit;
  logic [1:0]            iface_d;

  assign go_ext      = strobe && (space == SP_EXT);
  assign in_dram_grp = is_dram_area(area);
  assign eff_kind    = (merged && in_dram_grp) ? IF_DRAM : kinds[area];
  assign use_ras     = in_dram_grp && (eff_kind == IF_DRAM);
  assign slot        = ras_slot(area, merged);
  assign iface_d     = go_ext ? eff_kind : IF_BASIC;

  for (genvar gi = 0; gi < NUM_SEL; gi++) begin : g_cs
    assign cs_hit[gi] = go_ext && !use_ras && (area == AREA_W'(gi));
  end

  for (genvar gr = 0; gr < NUM_STROBE; gr++) begin : g_ras
    assign ras_hit[gr] = go_ext && use_ras && (slot == 2'(gr));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n      <= '1;
      ras_n     <= '1;
      acc_iface <= IF_BASIC;
      hit_rom   <= 1'b0;
      hit_ram   <= 1'b0;
      hit_reg   <= 1'b0;
      hit_ext   <= 1'b0;
      hit_bad   <= 1'b0;
    end else begin
      cs_n      <= ~cs_hit;
      ras_n     <= ~ras_hit;
      acc_iface <= iface_d;
      hit_rom   <= strobe && (space == SP_ROM);
      hit_ram   <= strobe && (space == SP_RAM);
      hit_reg   <= strobe && (space == SP_REG);
      hit_ext   <= go_ext;
      hit_bad   <= strobe && (space == SP_BAD);
    end
  end

endmodule

// File: rtl/area_cs_decoder.sv
module area_cs_decoder
  import acd_pkg::*;
#(
  parameter int          ADDR_W   = 24,
  parameter logic [31:0] ROM_SIZE = 32'h0004_0000,
  parameter logic [31:0] RAM_BASE = 32'h00FF_B000,
  parameter logic [31:0] RAM_SIZE = 32'h0000_4000,
  parameter logic [31:0] REG_BASE = 32'h00FF_F000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_expanded,
  input  logic               rom_enable,
  input  logic               ram_enable,
  input  logic               cfg_wr,
  input  logic [2:0]         cfg_area,
  input  logic [1:0]         cfg_iface,
  input  logic               cfg_merge_wr,
  input  logic               cfg_merge,
  input  logic               acc_strobe,
  input  logic [ADDR_W-1:0]  acc_addr,
  output logic [6:0]         cs_n,
  output logic [3:0]         ras_n,
  output logic [1:0]         acc_iface,
  output logic               hit_rom,
  output logic               hit_ram,
  output logic               hit_reg,
  output logic               hit_ext,
  output logic               hit_bad
);

  // named internal state, visible to the bound checker
  logic [NUM_AREAS-1:0][1:0] types_q;
  logic                      merge_q;
  logic [AREA_W-1:0]         dec_area;
  space_e                    dec_space;

  acd_cfg_regs #(
    .AREAS (NUM_AREAS)
  ) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_wr),
    .wr_area  (cfg_area),
    .wr_kind  (cfg_iface),
    .merge_wr (cfg_merge_wr),
    .merge_in (cfg_merge),
    .kinds_q  (types_q),
    .merge_q  (merge_q)
  );

  acd_region_decode #(
    .ADDR_W   (ADDR_W),
    .ROM_SIZE (ROM_SIZE),
    .RAM_BASE (RAM_BASE),
    .RAM_SIZE (RAM_SIZE),
    .REG_BASE (REG_BASE)
  ) u_dec (
    .addr          (acc_addr),
    .mode_expanded (mode_expanded),
    .rom_enable    (rom_enable),
    .ram_enable    (ram_enable),
    .area          (dec_area),
    .space         (dec_space)
  );

  acd_select_drive #(
    .AREAS      (NUM_AREAS),
    .NUM_SEL    (NUM_CS),
    .NUM_STROBE (NUM_RAS)
  ) u_drv (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (acc_strobe),
    .area      (dec_area),
    .space     (dec_space),
    .kinds     (types_q),
    .merged    (merge_q),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .acc_iface (acc_iface),
    .hit_rom   (hit_rom),
    .hit_ram   (hit_ram),
    .hit_reg   (hit_reg),
    .hit_ext   (hit_ext),
    .hit_bad   (hit_bad)
  );

endmodule

// File: rtl/acd_checker.sv
module acd_checker #(
  parameter int AREAS = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  acc_strobe,
  input logic                  mode_expanded,
  input logic [6:0]            cs_n,
  input logic [3:0]            ras_n,
  input logic                  hit_rom,
  input logic                  hit_ram,
  input logic                  hit_reg,
  input logic                  hit_ext,
  input logic                  hit_bad,
  input logic [AREAS-1:0][1:0] types_q,
  input logic                  merge_q
);

  // R2
  one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~cs_n, ~ras_n}) <= 1);

  // R2
  flag_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit_rom, hit_ram, hit_reg, hit_ext, hit_bad}));

  // R2
  sel_needs_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(&cs_n && &ras_n) |-> hit_ext);

  // R8
  single_chip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(acc_strobe) && !$past(mode_expanded)) |-> (&cs_n && &ras_n && !hit_ext));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(acc_strobe) |->
      (&cs_n && &ras_n && !(hit_rom || hit_ram || hit_reg || hit_ext || hit_bad)));

  // R7
  merge_single_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(merge_q) |-> (&ras_n[3:1]));

  // R5
  area6_basic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    types_q[6] == 2'b00 && types_q[7] == 2'b00);

  // R5
  low_areas_no_dram_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !types_q[0][1] && !types_q[1][1]);

  // R5
  mid_areas_no_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !types_q[2][0] && !types_q[3][0] && !types_q[4][0] && !types_q[5][0]);

endmodule

bind area_cs_decoder acd_checker #(.AREAS(8)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .acc_strobe    (acc_strobe),
  .mode_expanded (mode_expanded),
  .cs_n          (cs_n),
  .ras_n         (ras_n),
  .hit_rom       (hit_rom),
  .hit_ram       (hit_ram),
  .hit_reg       (hit_reg),
  .hit_ext       (hit_ext),
  .hit_bad       (hit_bad),
  .types_q       (types_q),
  .merge_q       (merge_q)
);

// File: tb/area_cs_decoder_test.sv
module area_cs_decoder_test;

  localparam int CLK_PERIOD = 10;

  localparam logic [1:0] K_BASIC = 2'b00;
  localparam logic [1:0] K_BURST = 2'b01;
  localparam logic [1:0] K_DRAM  = 2'b10;
  localparam logic [1:0] K_RSVD  = 2'b11;

  // flag order: {rom, ram, reg, ext, bad}
  localparam logic [4:0] F_ROM = 5'b10000;
  localparam logic [4:0] F_RAM = 5'b01000;
  localparam logic [4:0] F_REG = 5'b00100;
  localparam logic [4:0] F_EXT = 5'b00010;
  localparam logic [4:0] F_BAD = 5'b00001;

  typedef struct packed {
    logic        ex;
    logic        rom;
    logic        ram;
    logic [23:0] addr;
    logic [6:0]  cs;
    logic [4:0]  fl;
  } vec_t;

  localparam int NVEC = 21;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b1, 1'b1, 24'h000100, 7'h7F, F_ROM},
    '{1'b1, 1'b1, 1'b1, 24'h050000, 7'h7E, F_EXT},
    '{1'b1, 1'b0, 1'b1, 24'h000100, 7'h7E, F_EXT},
    '{1'b1, 1'b1, 1'b1, 24'h03FFFF, 7'h7F, F_ROM},
    '{1'b1, 1'b1, 1'b1, 24'h040000, 7'h7E, F_EXT},
    '{1'b1, 1'b1, 1'b1, 24'h200000, 7'h7D, F_EXT},
    '{1'b1, 1'b1, 1'b1, 24'h5A0000, 7'h7B, F_EXT},
    '{1'b1, 1'b1, 1'b1, 24'h612345, 7'h77, F_EXT},
    '{1'b1, 1'b1, 1'b1, 24'h9FFFFF, 7'h6F, F_EXT},
    '{1'b1, 1'b1, 1'b1, 24'hA00000, 7'h5F, F_EXT},
    '{1'b1, 1'b1, 1'b1, 24'hC00000, 7'h3F, F_EXT},
    '{1'b1, 1'b1, 1'b1, 24'hE00000, 7'h7F, F_EXT},
    '{1'b1, 1'b1, 1'b1, 24'hFFB000, 7'h7F, F_RAM},
    '{1'b1, 1'b1, 1'b0, 24'hFFEFFF, 7'h7F, F_EXT},
    '{1'b1, 1'b1, 1'b1, 24'hFFAFFF, 7'h7F, F_EXT},
    '{1'b1, 1'b1, 1'b1, 24'hFFF000, 7'h7F, F_REG},
    '{1'b1, 1'b1, 1'b1, 24'hFFFFFF, 7'h7F, F_REG},
    '{1'b0, 1'b1, 1'b1, 24'h200000, 7'h7F, F_BAD},
    '{1'b0, 1'b1, 1'b1, 24'h000000, 7'h7F, F_ROM},
    '{1'b0, 1'b1, 1'b1, 24'hFFC000, 7'h7F, F_RAM},
    '{1'b0, 1'b1, 1'b0, 24'hFFB000, 7'h7F, F_BAD}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_expanded = 1'b0;
  logic        rom_enable = 1'b0;
  logic        ram_enable = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_area = '0;
  logic [1:0]  cfg_iface = '0;
  logic        cfg_merge_wr = 1'b0;
  logic        cfg_merge = 1'b0;
  logic        acc_strobe = 1'b0;
  logic [23:0] acc_addr = '0;
  logic [6:0]  cs_n;
  logic [3:0]  ras_n;
  logic [1:0]  acc_iface;
  logic        hit_rom, hit_ram, hit_reg, hit_ext, hit_bad;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  area_cs_decoder uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_expanded (mode_expanded),
    .rom_enable    (rom_enable),
    .ram_enable    (ram_enable),
    .cfg_wr        (cfg_wr),
    .cfg_area      (cfg_area),
    .cfg_iface     (cfg_iface),
    .cfg_merge_wr  (cfg_merge_wr),
    .cfg_merge     (cfg_merge),
    .acc_strobe    (acc_strobe),
    .acc_addr      (acc_addr),
    .cs_n          (cs_n),
    .ras_n         (ras_n),
    .acc_iface     (acc_iface),
    .hit_rom       (hit_rom),
    .hit_ram       (hit_ram),
    .hit_reg       (hit_reg),
    .hit_ext       (hit_ext),
    .hit_bad       (hit_bad)
  );

  task automatic check_out(input string req, input logic [6:0] e_cs,
                           input logic [3:0] e_ras, input logic [4:0] e_fl,
                           input logic [1:0] e_if);
    logic [4:0] fl;
    fl = {hit_rom, hit_ram, hit_reg, hit_ext, hit_bad};
    total++;
    if (cs_n !== e_cs || ras_n !== e_ras || fl !== e_fl || acc_iface !== e_if) begin
      bad++;
      $display("FAIL %s: got cs_n=%b ras_n=%b flags=%b iface=%b, expected cs_n=%b ras_n=%b flags=%b iface=%b",
               req, cs_n, ras_n, fl, acc_iface, e_cs, e_ras, e_fl, e_if);
    end
  endtask

  // one strobed access; outputs sampled at the negedge after the capturing edge
  task automatic access(input logic ex, input logic rom, input logic ram,
                        input logic [23:0] a);
    @(negedge clk);
    mode_expanded = ex;
    rom_enable    = rom;
    ram_enable    = ram;
    acc_addr      = a;
    acc_strobe    = 1'b1;
    @(negedge clk);
    acc_strobe    = 1'b0;
  endtask

  task automatic write_kind(input logic [2:0] area, input logic [1:0] kind);
    @(negedge clk);
    cfg_wr    = 1'b1;
    cfg_area  = area;
    cfg_iface = kind;
    @(negedge clk);
    cfg_wr    = 1'b0;
  endtask

  task automatic write_merge(input logic on);
    @(negedge clk);
    cfg_merge_wr = 1'b1;
    cfg_merge    = on;
    @(negedge clk);
    cfg_merge_wr = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check_out("R1 in reset", 7'h7F, 4'hF, 5'b0, K_BASIC);
    rst_n = 1'b1;
    @(negedge clk);
    check_out("R1 after release", 7'h7F, 4'hF, 5'b0, K_BASIC);

    // R2/R3/R4/R8 table with default kinds
    for (int i = 0; i < NVEC; i++) begin
      access(VECS[i].ex, VECS[i].rom, VECS[i].ram, VECS[i].addr);
      check_out($sformatf("R2/R3/R4/R8 vec %0d", i), VECS[i].cs, 4'hF, VECS[i].fl, K_BASIC);
    end

    // R9: idle cycle after access
    @(negedge clk);
    check_out("R9 idle", 7'h7F, 4'hF, 5'b0, K_BASIC);

    // R5: illegal and legal kind writes
    write_kind(3'd0, K_DRAM);
    access(1'b1, 1'b1, 1'b1, 24'h100000);
    check_out("R5 area0 dram ignored", 7'h7E, 4'hF, F_EXT, K_BASIC);
    write_kind(3'd0, K_BURST);
    access(1'b1, 1'b1, 1'b1, 24'h100000);
    check_out("R11 area0 burst", 7'h7E, 4'hF, F_EXT, K_BURST);
    write_kind(3'd0, K_RSVD);
    access(1'b1, 1'b1, 1'b1, 24'h100000);
    check_out("R5 area0 reserved ignored", 7'h7E, 4'hF, F_EXT, K_BURST);
    write_kind(3'd1, K_BURST);
    access(1'b1, 1'b1, 1'b1, 24'h200000);
    check_out("R5 area1 burst", 7'h7D, 4'hF, F_EXT, K_BURST);
    write_kind(3'd6, K_BURST);
    access(1'b1, 1'b1, 1'b1, 24'hC00000);
    check_out("R5 area6 burst ignored", 7'h3F, 4'hF, F_EXT, K_BASIC);
    write_kind(3'd2, K_BURST);
    access(1'b1, 1'b1, 1'b1, 24'h400000);
    check_out("R5 area2 burst ignored", 7'h7B, 4'hF, F_EXT, K_BASIC);
    write_kind(3'd7, K_DRAM);
    access(1'b1, 1'b1, 1'b1, 24'hE00000);
    check_out("R5 area7 dram ignored", 7'h7F, 4'hF, F_EXT, K_BASIC);

    // R6: per-area row strobes
    write_kind(3'd3, K_DRAM);
    access(1'b1, 1'b1, 1'b1, 24'h600000);
    check_out("R6 area3 ras", 7'h7F, 4'hD, F_EXT, K_DRAM);
    write_kind(3'd5, K_DRAM);
    access(1'b1, 1'b1, 1'b1, 24'hBFFFFF);
    check_out("R6 area5 ras", 7'h7F, 4'h7, F_EXT, K_DRAM);
    write_kind(3'd5, K_BASIC);
    access(1'b1, 1'b1, 1'b1, 24'hA00000);
    check_out("R6 area5 back to cs", 7'h5F, 4'hF, F_EXT, K_BASIC);

    // R10: write and access in the same cycle
    @(negedge clk);
    mode_expanded = 1'b1;
    cfg_wr     = 1'b1;
    cfg_area   = 3'd4;
    cfg_iface  = K_DRAM;
    acc_addr   = 24'h800000;
    acc_strobe = 1'b1;
    @(negedge clk);
    cfg_wr     = 1'b0;
    acc_strobe = 1'b0;
    check_out("R10 old kind used", 7'h6F, 4'hF, F_EXT, K_BASIC);
    access(1'b1, 1'b1, 1'b1, 24'h800000);
    check_out("R10 new kind next", 7'h7F, 4'hB, F_EXT, K_DRAM);

    // R7: merged DRAM space
    write_merge(1'b1);
    access(1'b1, 1'b1, 1'b1, 24'h400000);
    check_out("R7 merged area2", 7'h7F, 4'hE, F_EXT, K_DRAM);
    access(1'b1, 1'b1, 1'b1, 24'hA00000);
    check_out("R7 merged area5", 7'h7F, 4'hE, F_EXT, K_DRAM);
    access(1'b1, 1'b1, 1'b1, 24'h600000);
    check_out("R7 merged area3", 7'h7F, 4'hE, F_EXT, K_DRAM);
    access(1'b1, 1'b1, 1'b1, 24'hC00000);
    check_out("R7 area6 unaffected", 7'h3F, 4'hF, F_EXT, K_BASIC);
    write_merge(1'b0);
    access(1'b1, 1'b1, 1'b1, 24'h600000);
    check_out("R7 unmerged area3", 7'h7F, 4'hD, F_EXT, K_DRAM);

    // R8: single-chip with a DRAM area
    access(1'b0, 1'b1, 1'b1, 24'h600000);
    check_out("R8 single-chip dram area", 7'h7F, 4'hF, F_BAD, K_BASIC);
    access(1'b0, 1'b0, 1'b1, 24'h000100);
    check_out("R8 single-chip rom off", 7'h7F, 4'hF, F_BAD, K_BASIC);

    // R11: internal access reports basic even in burst area 0
    access(1'b1, 1'b1, 1'b1, 24'h000010);
    check_out("R11 rom hit iface", 7'h7F, 4'hF, F_ROM, K_BASIC);

    // R9: quiet after last access
    @(negedge clk);
    check_out("R9 idle end", 7'h7F, 4'hF, 5'b0, K_BASIC);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule